// File: doc/BRIEF.md
# Chained Byte Multiply-Accumulate Unit

This unit is the multiply engine of a small accumulator-style processor with an 8-bit working register. It offers two operations. The plain multiply takes the working register as one factor and an operand as the other. It also saves the working register in a multiplier register so that later steps can reuse it. The multiply-add reuses the saved multiplier. It multiplies that multiplier by the operand and adds the current product-high byte to the result. Both operations return the 16-bit result split in two: the upper byte goes to the product-high register and the lower byte becomes the new working-register value.

Each multiply-add picks up the high byte left by the previous step. A run of multiply-adds therefore sweeps an 8-bit multiplier across a multi-byte operand one byte at a time, and the carries pass between steps through the product-high register. This builds products of any width on one fixed 8x8 datapath. The arithmetic is shift-and-add and retires two multiplier bits per clock, so one operation takes four clocks. The multiplier register can also be written from outside at any time, so a new multiplier can be installed between chained steps.

The start, load and op-select pins are plain control strobes with no handshake. A start is taken only while the unit is idle. A start that arrives while the unit is busy is dropped, not held back, so the issuing sequencer must wait for `done` before it issues the next operation.

Top module: `chain_mul8`

## Requirements
- R1: While `rst_n` is low, and after it is released, `w_out`, `ph_out` and `mr_out` read 0, and `busy` and `done` are low.
- R2: A start taken with `op_sel`=0 (plain multiply) yields {`ph_out`,`w_out`} = `operand` × `w_in`. The high byte goes to `ph_out` and the low byte to `w_out`.
- R3: A start taken with `op_sel`=0 copies `w_in` into the multiplier register. `mr_out` shows the copy in the cycle after the start edge.
- R4: A start taken with `op_sel`=1 (multiply-add) yields {`ph_out`,`w_out`} = `ph_out` + `operand` × `mr_out`, using the values present at the start edge. The value on `w_in` has no effect on the result.
- R5: After a start is taken, `busy` is high for exactly 4 cycles. In the cycle after the last of them, `done` is high for a single cycle and the new results appear on `w_out` and `ph_out` in that same cycle.
- R6: `w_out` and `ph_out` do not change while `busy` is high.
- R7: A start strobe that arrives while `busy` is high is ignored. It does not change the result of the operation in progress and does not begin a second operation.
- R8: When `mr_load` is high on an edge, `mr_din` is written to the multiplier register. The one exception is an edge that takes a plain-multiply start, where the copy from R3 wins. This load works while the unit is busy and does not affect an operation already under way.
- R9: For 16-bit operands, the sequence plain multiply, multiply-add, plain multiply (on the high byte of the first operand), multiply-add, with the bytes combined by add-with-carry, reproduces the full 32-bit product.
- R10: In the largest reachable case, a multiply-add with `ph_out`=0xFE and `operand`=`mr_out`=0xFF gives `ph_out`=0xFE and `w_out`=0xFF. The result always fits in 16 bits, so no carry flag is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe, taken only while idle |
| op_sel | input | 1 | 0 = plain multiply, 1 = multiply-add |
| operand | input | 8 | Operand byte |
| w_in | input | 8 | Current working-register value |
| mr_load | input | 1 | Direct write strobe for the multiplier register |
| mr_din | input | 8 | Value for the direct multiplier write |
| w_out | output | 8 | New working-register value (low result byte) |
| ph_out | output | 8 | Product-high register |
| mr_out | output | 8 | Multiplier register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking the cycle in which the results appear |

## Verification
Faults in the internal state show up at the ports at the first `done` after the bad state begins:

- A wrong partial sum or shifted multiplicand gives a wrong {`ph_out`,`w_out`} on that pulse.
- A wrong step counter moves `done` away from the fifth cycle after the start, or leaves `busy` stuck.
- A multiply-add seeded from the wrong place, or a multiplier register that was overwritten or not copied, shows only on the next multiply-add.

The chained byte products are compared against full 32-bit products. This catches such carry faults even when they are masked within a single step.

// File: rtl/chain_mul8_pkg.sv
package chain_mul8_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_MAD = 1'b1
  } mul_op_e;
endpackage

// File: rtl/cm8_seq.sv
// Step sequencer: accepts a start when idle, counts datapath steps,
// flags the final step and pulses done afterwards.
module cm8_seq #(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign accept  = start && !busy_q;
  assign step_en = busy_q;
  assign finish  = busy_q && (cnt_q == LAST);
  assign busy    = busy_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) busy_q <= 1'b0;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cm8_step.sv
// One radix-2^BPS shift-add step: adds the multiplicand, shifted by each
// multiplier bit position of this step, to the running sum.
module cm8_step #(
  parameter int DW  = 8,
  parameter int BPS = 2
) (
  input  logic [2*DW-1:0] acc,
  input  logic [2*DW-1:0] mcand_sh,
  input  logic [BPS-1:0]  bits,
  output logic [2*DW-1:0] sum
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] term [BPS];

  for (genvar g = 0; g < BPS; g++) begin : g_term
    assign term[g] = bits[g] ? (mcand_sh << g) : '0;
  end

  always_comb begin
    sum = acc;
    for (int i = 0; i < BPS; i++) sum = sum + term[i];
  end
endmodule

// File: rtl/cm8_arch.sv
// Architectural registers: working byte, product-high byte, multiplier.
module cm8_arch #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            copy_mul,
  input  logic [DW-1:0]   w_in,
  input  logic            ext_load,
  input  logic [DW-1:0]   ext_din,
  input  logic            finish,
  input  logic [2*DW-1:0] result,
  output logic [DW-1:0]   w_q,
  output logic [DW-1:0]   ph_q,
  output logic [DW-1:0]   mr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q  <= '0;
      ph_q <= '0;
      mr_q <= '0;
    end else begin
      if (copy_mul)      mr_q <= w_in;
      else if (ext_load) mr_q <= ext_din;
      if (finish) begin
        ph_q <= result[2*DW-1:DW];
        w_q  <= result[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/chain_mul8.sv
module chain_mul8 #(
  parameter int DW  = 8,
  parameter int BPS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sel,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] w_in,
  input  logic          mr_load,
  input  logic [DW-1:0] mr_din,
  output logic [DW-1:0] w_out,
  output logic [DW-1:0] ph_out,
  output logic [DW-1:0] mr_out,
  output logic          busy,
  output logic          done
);
  import chain_mul8_pkg::*;

  localparam int NSTEP = DW / BPS;
  localparam int PW    = 2 * DW;

  mul_op_e op;
  assign op = mul_op_e'(op_sel);

  logic accept, step_en, finish;
  logic [PW-1:0] acc_q, mcand_q, sum;
  logic [DW-1:0] mplier_q;

  cm8_seq #(.STEPS(NSTEP)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .step_en (step_en),
    .finish  (finish),
    .busy    (busy),
    .done    (done)
  );

  cm8_step #(.DW(DW), .BPS(BPS)) u_step (
    .acc      (acc_q),
    .mcand_sh (mcand_q),
    .bits     (mplier_q[BPS-1:0]),
    .sum      (sum)
  );

  cm8_arch #(.DW(DW)) u_arch (
    .clk      (clk),
    .rst_n    (rst_n),
    .copy_mul (accept && (op == OP_MUL)),
    .w_in     (w_in),
    .ext_load (mr_load),
    .ext_din  (mr_din),
    .finish   (finish),
    .result   (sum),
    .w_q      (w_out),
    .ph_q     (ph_out),
    .mr_q     (mr_out)
  );

  // Datapath: the multiply-add seeds its sum with product-high, so the
  // addition comes free with the shift-add steps.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (accept) begin
      acc_q    <= (op == OP_MAD) ? {{DW{1'b0}}, ph_out} : '0;
      mcand_q  <= {{DW{1'b0}}, operand};
      mplier_q <= (op == OP_MAD) ? mr_out : w_in;
    end else if (step_en) begin
      acc_q    <= sum;
      mcand_q  <= mcand_q << BPS;
      mplier_q <= mplier_q >> BPS;
    end
  end
endmodule

// File: rtl/chain_mul8_chk.sv
module chain_mul8_chk #(
  parameter int DW    = 8,
  parameter int STEPS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          op_sel,
  input logic [DW-1:0] w_in,
  input logic          mr_load,
  input logic [DW-1:0] mr_din,
  input logic [DW-1:0] w_out,
  input logic [DW-1:0] ph_out,
  input logic [DW-1:0] mr_out,
  input logic          busy,
  input logic          done
);
  logic [7:0] bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < 8'(STEPS)));
  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(w_out) && $stable(ph_out)));
  // R3
  mr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start && !busy && !op_sel) |-> (mr_out == $past(w_in)));
  // R7
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && (bcnt < 8'(STEPS - 1))) |=> busy);
  // R8
  mr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mr_load && !(start && !busy && !op_sel)) |-> (mr_out == $past(mr_din)));
  // R8
  mr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mr_load && !(start && !busy && !op_sel)) |-> $stable(mr_out));
endmodule

bind chain_mul8 chain_mul8_chk #(.DW(DW), .STEPS(NSTEP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op_sel  (op_sel),
  .w_in    (w_in),
  .mr_load (mr_load),
  .mr_din  (mr_din),
  .w_out   (w_out),
  .ph_out  (ph_out),
  .mr_out  (mr_out),
  .busy    (busy),
  .done    (done)
);

// File: tb/test_chain_mul8.sv
`timescale 1ns/1ps
module test_chain_mul8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       op_sel = 1'b0;
  logic [7:0] operand = '0;
  logic [7:0] w_in = '0;
  logic       mr_load = 1'b0;
  logic [7:0] mr_din = '0;
  logic [7:0] w_out, ph_out, mr_out;
  logic       busy, done;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [15:0] q_val[$];
  string       q_tag[$];
  logic [7:0]  ph_m = '0, mr_m = '0;
  logic [7:0]  res_w, res_ph;

  always #5 clk = ~clk;

  chain_mul8 i_chain_mul8 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .operand(operand), .w_in(w_in), .mr_load(mr_load), .mr_din(mr_din),
    .w_out(w_out), .ph_out(ph_out), .mr_out(mr_out), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every done pops one expected result.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_val.size() == 0) begin
        chk("R7 unexpected done", 32'(done), 32'd0);
      end else begin
        logic [15:0] e;
        string t;
        e = q_val.pop_front();
        t = q_tag.pop_front();
        chk(t, {16'd0, ph_out, w_out}, {16'd0, e});
      end
    end
  end

  // Driver: computes the expected result, queues it and runs the operation.
  // glitch: extra start while busy (R7); ld: direct multiplier write while busy (R8).
  task automatic run_op(input logic op, input logic [7:0] opd, input logic [7:0] w,
                        input string tag, input bit glitch, input bit ld,
                        input logic [7:0] ld_val);
    logic [15:0] e;
    int bc;
    e = op ? (16'(ph_m) + 16'(opd) * 16'(mr_m)) : (16'(opd) * 16'(w));
    if (!op) mr_m = w;
    ph_m = e[15:8];
    q_val.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b1; op_sel = op; operand = opd; w_in = w;
    @(negedge clk);
    start = 1'b0; w_in = 8'hA5; operand = 8'h5A;
    bc = 0;
    while (busy && bc < 20) begin
      bc++;
      start   = (glitch && bc == 2);
      op_sel  = glitch ? 1'b1 : op_sel;
      operand = glitch ? 8'h77 : operand;
      mr_load = (ld && bc == 1);
      mr_din  = ld_val;
      if (ld && bc == 1) mr_m = ld_val;
      @(negedge clk);
    end
    start = 1'b0; mr_load = 1'b0;
    chk("R5 busy length", 32'(bc), 32'd4);
    chk("R5 done pulse", 32'(done), 32'd1);
    res_w = w_out;
    res_ph = ph_out;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset w", 32'(w_out), 0);
    chk("R1 reset ph", 32'(ph_out), 0);
    chk("R1 reset mr", 32'(mr_out), 0);
    chk("R1 reset busy/done", {30'd0, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {8'd0, w_out, ph_out, mr_out}, 0);

    // Plain multiply and multiplier copy
    run_op(1'b0, 8'h0C, 8'h0B, "R2 plain mul", 0, 0, 8'h00);
    chk("R3 multiplier copy", 32'(mr_out), 32'h0B);
    // Multiply-add, w_in driven with junk
    run_op(1'b1, 8'h10, 8'hFF, "R4 multiply-add", 0, 0, 8'h00);
    chk("R4 result", {16'd0, res_ph, res_w}, 32'h00B0);
    // Largest reachable value
    run_op(1'b0, 8'hFF, 8'hFF, "R2 max plain", 0, 0, 8'h00);
    run_op(1'b1, 8'hFF, 8'h00, "R10 max multiply-add", 0, 0, 8'h00);
    chk("R10 result", {16'd0, res_ph, res_w}, 32'hFEFF);
    // Zero operand
    run_op(1'b0, 8'h00, 8'h5A, "R2 zero operand", 0, 0, 8'h00);
    // Start during busy is dropped
    run_op(1'b0, 8'h03, 8'h05, "R7 result kept", 1, 0, 8'h00);
    chk("R7 multiplier kept", 32'(mr_out), 32'h05);
    repeat (6) @(negedge clk);
    chk("R7 no second op", 32'(busy), 0);
    // Direct multiplier load while idle and while busy
    @(negedge clk); mr_load = 1'b1; mr_din = 8'h21;
    @(negedge clk); mr_load = 1'b0;
    mr_m = 8'h21;
    chk("R8 idle load", 32'(mr_out), 32'h21);
    run_op(1'b1, 8'h02, 8'h99, "R8 load during busy", 0, 1, 8'h40);
    chk("R8 old multiplier used", {16'd0, res_ph, res_w}, 32'h0042);
    chk("R8 new multiplier visible", 32'(mr_out), 32'h40);

    // Chained 16x16 products
    for (int k = 0; k < 25; k++) begin
      logic [15:0] a, b;
      logic [31:0] prod;
      logic [7:0] r0, t1, t2, u1, u2, u3;
      a = 16'($urandom);
      b = 16'($urandom);
      if (k == 0) begin a = 16'hFFFF; b = 16'hFFFF; end
      run_op(1'b0, b[7:0], a[7:0], "R9 step", 0, 0, 8'h00);  r0 = res_w;
      run_op(1'b1, b[15:8], 8'h00, "R9 step", 0, 0, 8'h00);  t1 = res_w; t2 = res_ph;
      run_op(1'b0, b[7:0], a[15:8], "R9 step", 0, 0, 8'h00); u1 = res_w;
      run_op(1'b1, b[15:8], 8'h00, "R9 step", 0, 0, 8'h00);  u2 = res_w; u3 = res_ph;
      prod = 32'(r0) + (32'({t2, t1}) << 8) + (32'({u3, u2, u1}) << 8);
      chk("R9 32-bit product", prod, 32'(a) * 32'(b));
    end

    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", 32'(q_val.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule